// File: doc/BRIEF.md
# Majority-Vote Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps three tables of two-bit saturating counters. Each table is indexed in a different way: the first by the branch address alone, the second by the branch address XORed with a global history of recent outcomes, and the third by the history alone. The final guess is the majority of the three counters' upper bits. Aliasing that corrupts one table is therefore outvoted by the other two.

A lookup returns the prediction combinationally. It also exposes the current history, which the caller keeps as a snapshot. When the caller asserts the lookup valid, the predicted direction is shifted speculatively into the history. When the branch later resolves, the caller returns the address, the real outcome, the snapshot and a mispredict flag. The block then trains all three counters that the lookup used. On a mispredict it also rebuilds the history from the snapshot.

The block also contains a small return-address stack. A call pushes its return address and a return pops it.

Top module: `mvote_bpred`

## Requirements
- R1: After reset every counter holds 01 (weakly not taken), the history is zero, the stack is empty and its top reads zero, so every lookup predicts not taken.
- R2: `lk_taken` is 1 exactly when at least two of the three selected counters have their upper bit set. A single strong vote does not decide the result.
- R3: The three tables use these indices: the address field `pc_idx`; `pc_idx` XOR history; and the history alone. `pc_idx` holds branch address bits [9:2].
- R4: On `rs_valid`, each table's counter at the index formed from `rs_pc_idx` and `rs_hist` is updated. It is incremented when `rs_taken`=1 and decremented otherwise, and it saturates at 3 and at 0.
- R5: `lk_hist` shows the current history. When `lk_valid`=1, the next history is the old history shifted left by one, with `lk_taken` in bit 0.
- R6: When `rs_valid` and `rs_mispred` are both 1, the next history is `{rs_hist[6:0], rs_taken}`. This takes priority over a shift from a lookup in the same cycle.
- R7: A resolve without `rs_mispred` leaves the history unchanged. So does a cycle with no valid lookup.
- R8: A push makes `ras_top` show the pushed address and clears `ras_empty`. Pops return entries in last-in, first-out order.
- R9: The stack holds 8 entries. A ninth push overwrites the oldest entry, so eight pops return the eight newest addresses.
- R10: `ras_empty` is 1 when the stack holds no entries. In that state `ras_top` shows the most recently popped entry, and a pop changes neither output.
- R11: A push and a pop in the same cycle on a non-empty stack replace the top entry and leave the depth unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup accepted; shifts the predicted direction into the history |
| lk_pc_idx | input | 8 | Branch address bits [9:2] for the lookup |
| lk_taken | output | 1 | Predicted direction (1 = taken) |
| lk_hist | output | 8 | Current global history; the caller stores it as the snapshot |
| rs_valid | input | 1 | Resolve: train the counters |
| rs_pc_idx | input | 8 | Branch address bits [9:2] of the resolving branch |
| rs_taken | input | 1 | Actual outcome |
| rs_mispred | input | 1 | Prediction was wrong; repair the history |
| rs_hist | input | 8 | History snapshot taken at lookup |
| ras_push | input | 1 | Call: push a return address |
| ras_push_addr | input | 32 | Return address to push |
| ras_pop | input | 1 | Return: pop the top entry |
| ras_top | output | 32 | Predicted return target |
| ras_empty | output | 1 | Stack holds no entries |

## Verification
The bench trains single entries and then looks up addresses that share only the history-indexed counter with the trained entry. This separates a true majority vote from a simpler rule such as OR or a single table. Long runs of taken outcomes, then not-taken outcomes, on one address show whether the counters stop at 3 and at 0. The history is driven by lookup shifts, by mispredict repairs that coincide with a lookup, and by correct resolves, to tell apart the priority and the hold behaviour. The stack is tried with shallow push/pop sequences, pops below empty, a same-cycle push and pop, and nine pushes that force wrap-around.

// File: rtl/mvb_pkg.sv
`timescale 1ns/1ps
// mvb_pkg: counter type and helpers shared by the predictor.
// Assumes two-bit counters; the upper bit is the direction vote.
package mvb_pkg;
    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'b01;
    localparam int   N_TABLES = 3;

    // Saturating step of a two-bit counter toward the observed outcome.
    function automatic ctr_t ctr_next(input ctr_t c, input logic up);
        if (up)
            return (c == 2'b11) ? c : c + 2'b01;
        else
            return (c == 2'b00) ? c : c - 2'b01;
    endfunction

    // Majority of three votes.
    function automatic logic vote3(input logic a, input logic b, input logic c);
        return (a & b) | (a & c) | (b & c);
    endfunction
endpackage

// File: rtl/mvb_table.sv
`timescale 1ns/1ps
// mvb_table: one table of two-bit saturating counters.
// Has one combinational read port and one write port that trains a counter.
// Assumes that a read and a write to the same entry in one cycle return the old value.
module mvb_table
    import mvb_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_vote,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int ENTRIES = 1 << IDX_W;

    ctr_t ctr [ENTRIES];

    // Read the direction vote of the addressed counter.
    assign rd_vote = ctr[rd_idx][1];

    // Reset all counters to weakly not taken, or train one on resolve.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) ctr[i] <= CTR_INIT;
        end else if (wr_en) begin
            ctr[wr_idx] <= ctr_next(ctr[wr_idx], wr_taken);
        end
    end
endmodule

// File: rtl/mvb_ghr.sv
`timescale 1ns/1ps
// mvb_ghr: global branch history register.
// Shifts in the predicted direction on each accepted lookup. On a
// mispredict it is rebuilt from the snapshot; the repair wins over the shift.
module mvb_ghr #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              fix_en,
    input  logic [HIST_W-2:0] fix_low,
    input  logic              fix_bit,
    output logic [HIST_W-1:0] hist
);
    // Update the history: repair, speculative shift, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hist <= '0;
        else if (fix_en)
            hist <= {fix_low, fix_bit};
        else if (shift_en)
            hist <= {hist[HIST_W-2:0], shift_bit};
    end
endmodule

// File: rtl/mvb_ras.sv
`timescale 1ns/1ps
// mvb_ras: circular return-address stack.
// DEPTH must be a power of two. When the stack is full, a push overwrites the
// oldest entry. When it is empty, the top output shows the last popped entry.
module mvb_ras #(
    parameter int DEPTH = 8,
    parameter int AW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic          pop,
    output logic [AW-1:0] top,
    output logic          empty
);
    localparam int PW = $clog2(DEPTH);
    localparam logic [PW:0] FULL = DEPTH[PW:0];

    logic [AW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr;
    logic [PW-1:0] tptr;
    logic [PW:0]   cnt;

    // Index of the newest live entry.
    assign tptr  = wptr - 1'b1;
    assign empty = (cnt == '0);
    // Show the newest entry, or the slot just vacated when the stack is empty.
    assign top   = empty ? mem[wptr] : mem[tptr];

    // Push, pop or replace the top entry, and track the depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
            wptr <= '0;
            cnt  <= '0;
        end else if (push && pop && !empty) begin
            mem[tptr] <= push_addr;
        end else if (push) begin
            mem[wptr] <= push_addr;
            wptr      <= wptr + 1'b1;
            if (cnt != FULL) cnt <= cnt + 1'b1;
        end else if (pop && !empty) begin
            wptr <= tptr;
            cnt  <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/mvote_bpred.sv
`timescale 1ns/1ps
// mvote_bpred: three-table majority-vote direction predictor with a
// return-address stack. The lookup is combinational. A resolve trains the
// counters at the indices formed from its own address and history snapshot.
// Assumes that callers pass branch address bits [IDX_W+1:2] as the pc index.
module mvote_bpred
    import mvb_pkg::*;
#(
    parameter int IDX_W     = 8,
    parameter int RAS_DEPTH = 8,
    parameter int RA_W      = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lk_valid,
    input  logic [IDX_W-1:0] lk_pc_idx,
    output logic             lk_taken,
    output logic [IDX_W-1:0] lk_hist,
    input  logic             rs_valid,
    input  logic [IDX_W-1:0] rs_pc_idx,
    input  logic             rs_taken,
    input  logic             rs_mispred,
    input  logic [IDX_W-1:0] rs_hist,
    input  logic             ras_push,
    input  logic [RA_W-1:0]  ras_push_addr,
    input  logic             ras_pop,
    output logic [RA_W-1:0]  ras_top,
    output logic             ras_empty
);
    logic [N_TABLES-1:0] votes;
    logic [IDX_W-1:0]    ghr;

    assign lk_hist = ghr;

    // One table per hash: 0 = address, 1 = address XOR history, 2 = history.
    for (genvar t = 0; t < N_TABLES; t++) begin : g_tab
        logic [IDX_W-1:0] rd_idx;
        logic [IDX_W-1:0] wr_idx;

        if (t == 0) begin : g_addr
            assign rd_idx = lk_pc_idx;
            assign wr_idx = rs_pc_idx;
        end else if (t == 1) begin : g_xor
            assign rd_idx = lk_pc_idx ^ ghr;
            assign wr_idx = rs_pc_idx ^ rs_hist;
        end else begin : g_hist
            assign rd_idx = ghr;
            assign wr_idx = rs_hist;
        end

        mvb_table #(.IDX_W(IDX_W)) u_table (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_idx   (rd_idx),
            .rd_vote  (votes[t]),
            .wr_en    (rs_valid),
            .wr_idx   (wr_idx),
            .wr_taken (rs_taken)
        );
    end

    // Combine the three table votes.
    assign lk_taken = vote3(votes[0], votes[1], votes[2]);

    mvb_ghr #(.HIST_W(IDX_W)) u_ghr (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (lk_valid),
        .shift_bit (lk_taken),
        .fix_en    (rs_valid & rs_mispred),
        .fix_low   (rs_hist[IDX_W-2:0]),
        .fix_bit   (rs_taken),
        .hist      (ghr)
    );

    mvb_ras #(.DEPTH(RAS_DEPTH), .AW(RA_W)) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ras_push),
        .push_addr (ras_push_addr),
        .pop       (ras_pop),
        .top       (ras_top),
        .empty     (ras_empty)
    );
endmodule

// File: rtl/mvote_bpred_chk.sv
`timescale 1ns/1ps
// mvote_bpred_chk: temporal checks on the predictor's ports, attached by bind.
module mvote_bpred_chk #(
    parameter int IDX_W = 8,
    parameter int RA_W  = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             lk_taken,
    input logic [IDX_W-1:0] lk_hist,
    input logic             rs_valid,
    input logic             rs_taken,
    input logic             rs_mispred,
    input logic [IDX_W-2:0] rs_hist_low,
    input logic             ras_push,
    input logic [RA_W-1:0]  ras_push_addr,
    input logic             ras_pop,
    input logic [RA_W-1:0]  ras_top,
    input logic             ras_empty
);
    // R5: an accepted lookup shifts its own prediction into the history.
    p_hist_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !(rs_valid && rs_mispred)) |=>
            lk_hist == {$past(lk_hist[IDX_W-2:0]), $past(lk_taken)});

    // R6: a mispredict rebuilds the history from the snapshot.
    p_hist_repair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_mispred) |=>
            lk_hist == {$past(rs_hist_low), $past(rs_taken)});

    // R7: with no lookup and no repair, the history holds.
    p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lk_valid && !(rs_valid && rs_mispred)) |=> $stable(lk_hist));

    // R8: a lone push appears on the top and clears empty.
    p_push_top_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_push && !ras_pop) |=> (ras_top == $past(ras_push_addr)) && !ras_empty);

    // R10: a pop on an empty stack changes nothing.
    p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_pop && !ras_push && ras_empty) |=> ras_empty && $stable(ras_top));

    // R11: push and pop together on a non-empty stack replace the top.
    p_replace_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_push && ras_pop && !ras_empty) |=>
            !ras_empty && (ras_top == $past(ras_push_addr)));

    // R8: an idle stack keeps its outputs.
    p_ras_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_push && !ras_pop) |=> $stable(ras_top) && $stable(ras_empty));
endmodule

bind mvote_bpred mvote_bpred_chk #(.IDX_W(IDX_W), .RA_W(RA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .lk_valid      (lk_valid),
    .lk_taken      (lk_taken),
    .lk_hist       (lk_hist),
    .rs_valid      (rs_valid),
    .rs_taken      (rs_taken),
    .rs_mispred    (rs_mispred),
    .rs_hist_low   (rs_hist[IDX_W-2:0]),
    .ras_push      (ras_push),
    .ras_push_addr (ras_push_addr),
    .ras_pop       (ras_pop),
    .ras_top       (ras_top),
    .ras_empty     (ras_empty)
);

// File: tb/tb_mvote_bpred.sv
`timescale 1ns/1ps
// tb_mvote_bpred: directed scenarios, each task checking its own results.
module tb_mvote_bpred;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lk_valid = 1'b0;
    logic [7:0]  lk_pc_idx = '0;
    logic        lk_taken;
    logic [7:0]  lk_hist;
    logic        rs_valid = 1'b0;
    logic [7:0]  rs_pc_idx = '0;
    logic        rs_taken = 1'b0;
    logic        rs_mispred = 1'b0;
    logic [7:0]  rs_hist = '0;
    logic        ras_push = 1'b0;
    logic [31:0] ras_push_addr = '0;
    logic        ras_pop = 1'b0;
    logic [31:0] ras_top;
    logic        ras_empty;

    int n_chk = 0;
    int n_err = 0;

    // Reference model state, built from the requirements.
    logic [1:0] m_tab [3][256];
    logic [7:0] m_ghr;

    always #2.5 clk = ~clk;

    mvote_bpred dut (
        .clk(clk), .rst_n(rst_n),
        .lk_valid(lk_valid), .lk_pc_idx(lk_pc_idx), .lk_taken(lk_taken), .lk_hist(lk_hist),
        .rs_valid(rs_valid), .rs_pc_idx(rs_pc_idx), .rs_taken(rs_taken),
        .rs_mispred(rs_mispred), .rs_hist(rs_hist),
        .ras_push(ras_push), .ras_push_addr(ras_push_addr), .ras_pop(ras_pop),
        .ras_top(ras_top), .ras_empty(ras_empty)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // R3 index rule.
    function automatic logic [7:0] bidx(input int t, input logic [7:0] pc, input logic [7:0] h);
        if (t == 0) return pc;
        if (t == 1) return pc ^ h;
        return h;
    endfunction

    // R2 majority rule over the model counters.
    function automatic logic mpred(input logic [7:0] pc, input logic [7:0] h);
        int v = 0;
        for (int t = 0; t < 3; t++) if (m_tab[t][bidx(t, pc, h)][1]) v++;
        return v >= 2;
    endfunction

    // One predictor cycle: drive, check the combinational outputs, clock, update the model.
    task automatic cyc(input logic lk, input logic [31:0] la, input logic rs,
                       input logic [31:0] ra, input logic rt, input logic rm, input logic [7:0] rh);
        logic p;
        @(negedge clk);
        lk_valid = lk; lk_pc_idx = la[9:2];
        rs_valid = rs; rs_pc_idx = ra[9:2]; rs_taken = rt; rs_mispred = rm; rs_hist = rh;
        #1;
        p = mpred(la[9:2], m_ghr);
        check("R2 model vote", {31'd0, lk_taken}, {31'd0, p});
        check("R5 history view", {24'd0, lk_hist}, {24'd0, m_ghr});
        @(posedge clk);
        if (rs) begin
            for (int t = 0; t < 3; t++) begin
                logic [1:0] c;
                c = m_tab[t][bidx(t, ra[9:2], rh)];
                if (rt && c != 2'b11) c = c + 2'b01;
                else if (!rt && c != 2'b00) c = c - 2'b01;
                m_tab[t][bidx(t, ra[9:2], rh)] = c;
            end
        end
        if (rs && rm) m_ghr = {rh[6:0], rt};
        else if (lk) m_ghr = {m_ghr[6:0], p};
        #1;
        lk_valid = 0; rs_valid = 0; rs_mispred = 0; rs_taken = 0;
    endtask

    // Look up without accepting, and compare against a literal and the model.
    task automatic peek(input logic [31:0] a, input logic exp, input string tag);
        @(negedge clk);
        lk_pc_idx = a[9:2];
        #1;
        check(tag, {31'd0, lk_taken}, {31'd0, exp});
        check({tag, " model"}, {31'd0, lk_taken}, {31'd0, mpred(a[9:2], m_ghr)});
    endtask

    task automatic ras_op(input logic pu, input logic po, input logic [31:0] a);
        @(negedge clk);
        ras_push = pu; ras_pop = po; ras_push_addr = a;
        @(posedge clk);
        #1;
        ras_push = 0; ras_pop = 0;
    endtask

    task automatic ras_chk(input logic [31:0] top, input logic emp, input string tag);
        @(negedge clk);
        check({tag, " top"}, ras_top, top);
        check({tag, " empty"}, {31'd0, ras_empty}, {31'd0, emp});
    endtask

    task automatic t_reset();
        // R1: reset state
        peek(32'h0000_0100, 1'b0, "R1 not taken after reset");
        peek(32'h0000_03FC, 1'b0, "R1 not taken after reset");
        check("R1 history zero", {24'd0, lk_hist}, 32'd0);
        ras_chk(32'd0, 1'b1, "R1 stack");
    endtask

    task automatic t_vote();
        // R4, R2, R3: one taken resolve moves three counters to 10.
        cyc(0, 0, 1, 32'h100, 1, 0, 8'h00);
        peek(32'h100, 1'b1, "R4 trained entry taken");
        peek(32'h104, 1'b0, "R2 one vote loses");
        cyc(0, 0, 1, 32'h104, 1, 0, 8'h55);
        peek(32'h104, 1'b1, "R3 address and history tables agree");
        peek(32'h108, 1'b0, "R3 xor index differs");
    endtask

    task automatic t_sat();
        // R4: saturation at 3 and at 0.
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 32'h200, 1, 0, 8'h00);
        cyc(0, 0, 1, 32'h200, 0, 0, 8'h00);
        peek(32'h200, 1'b1, "R4 saturated at 3");
        cyc(0, 0, 1, 32'h200, 0, 0, 8'h00);
        peek(32'h200, 1'b0, "R4 decrement");
        for (int i = 0; i < 4; i++) cyc(0, 0, 1, 32'h200, 0, 0, 8'h00);
        cyc(0, 0, 1, 32'h200, 1, 0, 8'h00);
        peek(32'h200, 1'b0, "R4 saturated at 0");
        cyc(0, 0, 1, 32'h200, 1, 0, 8'h00);
        peek(32'h200, 1'b1, "R4 increment");
    endtask

    task automatic t_hist();
        // R5: speculative shifts.
        cyc(1, 32'h200, 0, 0, 0, 0, 8'h00);
        cyc(1, 32'h300, 0, 0, 0, 0, 8'h00);
        @(negedge clk);
        check("R5 shifted history", {24'd0, lk_hist}, 32'h02);
        // R6: repair wins over a same-cycle shift.
        cyc(1, 32'h200, 1, 32'h040, 1, 1, 8'hA5);
        @(negedge clk);
        check("R6 repaired history", {24'd0, lk_hist}, 32'h4B);
        // R7: correct resolve leaves history alone.
        cyc(0, 0, 1, 32'h044, 0, 0, 8'h13);
        @(negedge clk);
        check("R7 history held", {24'd0, lk_hist}, 32'h4B);
    endtask

    task automatic t_ras();
        // R8: LIFO order.
        ras_op(1, 0, 32'h1000); ras_chk(32'h1000, 0, "R8 push1");
        ras_op(1, 0, 32'h2000);
        ras_op(1, 0, 32'h3000); ras_chk(32'h3000, 0, "R8 push3");
        ras_op(0, 1, 0);        ras_chk(32'h2000, 0, "R8 pop");
        ras_op(0, 1, 0);        ras_chk(32'h1000, 0, "R8 pop");
        // R10: empty behaviour.
        ras_op(0, 1, 0);        ras_chk(32'h1000, 1, "R10 emptied");
        ras_op(0, 1, 0);        ras_chk(32'h1000, 1, "R10 pop on empty");
        // R11: replace.
        ras_op(1, 0, 32'h000A);
        ras_op(1, 1, 32'h000B); ras_chk(32'h000B, 0, "R11 replaced");
        ras_op(0, 1, 0);        ras_chk(32'h000B, 1, "R11 depth kept");
    endtask

    task automatic t_wrap();
        // R9: nine pushes overwrite the oldest.
        for (int k = 1; k <= 9; k++) ras_op(1, 0, 32'h100 * k);
        for (int k = 9; k >= 2; k--) begin
            ras_chk(32'h100 * k, 0, "R9 wrapped order");
            ras_op(0, 1, 0);
        end
        ras_chk(32'h200, 1, "R9 eight entries only");
    endtask

    initial begin
        for (int t = 0; t < 3; t++)
            for (int i = 0; i < 256; i++) m_tab[t][i] = 2'b01;
        m_ghr = 8'h00;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_vote();
        t_sat();
        t_hist();
        t_ras();
        t_wrap();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog (all requirements) actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule